// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block executes one register-to-register addition over vector operands by walking the elements one at a time through a single shared adder. A caller presents a destination register number and two source register numbers, one flag per operand saying whether it is a vector or a scalar, an element count and a per-element write-enable mask. It then pulses `start`. For every element the sequencer issues a read of both sources to the register file. It adds the two values returned and writes the sum back only when that element's mask bit is set.

Each operand keeps its own element offset. The offset grows by one after each element only when the operand is flagged as a vector, so a scalar operand names the same register for every element. Elements whose mask bit is clear still advance every offset. Reads use a synchronous port: the address is presented in one cycle and the data returns in the next. The write port commits at the clock edge. A new element is issued every cycle, and its read overlaps the write of the element before it. An internal bypass therefore gives each element the value the previous element has just written. The register-file ports are plain, cycle-exact pins with no back-pressure: the register file must accept a read and a write on every cycle, and the sequencer never stalls.

Top module: `vec_elem_seq`

## Requirements
- R1: A `start` pulse seen while `busy` and `done` are both low is accepted, and all operand inputs are captured on that edge. `busy` is high from the next cycle until the final write cycle, inclusive. `done` pulses for one cycle in the final write cycle, so it is high N+1 cycles after the accepting edge for N elements.
- R2: The element count N is `vlen`, limited to 16 when `vlen` exceeds 16. Elements 0 to N-1 are issued on consecutive cycles, with exactly N read requests.
- R3: The register addressed for an operand is its base number plus its current offset, modulo 32.
- R4: An operand's offset starts at 0 and grows by one after each element only when that operand's vector flag is 1. A scalar operand uses its base register for every element.
- R5: Element i is written only when bit i of `pred_mask` is 1. Masked-off elements still advance all offsets.
- R6: Write data is the sum, modulo 2^32, of the two source values. It appears on the write port one cycle after that element's read request.
- R7: Results match strict element order: an element reading a register written by the previous element sees the new value.
- R8: A write aimed at register 0 is dropped (`rf_we` stays low), so register 0 keeps reading zero.
- R9: With `vlen` equal to 0, `done` pulses in the cycle after the accepting edge. `busy` stays low, and no read or write is issued.
- R10: `start` is ignored while `busy` or `done` is high. The running operation completes unchanged, and no second operation follows.
- R11: Out of reset, `busy`, `done`, `rf_re` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (single-cycle pulse) |
| vlen | input | 5 | Requested element count (0 to 31, limited to 16) |
| pred_mask | input | 16 | Per-element write enable, bit i for element i |
| rd_base | input | 5 | Destination base register number |
| rd_vec | input | 1 | Destination is a vector |
| rs1_base | input | 5 | First source base register number |
| rs1_vec | input | 1 | First source is a vector |
| rs2_base | input | 5 | Second source base register number |
| rs2_vec | input | 1 | Second source is a vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_re | output | 1 | Register-file read request |
| rf_raddr1 | output | 5 | Read address, first source |
| rf_raddr2 | output | 5 | Read address, second source |
| rf_rdata1 | input | 32 | Read data for `rf_raddr1`, one cycle after the request |
| rf_rdata2 | input | 32 | Read data for `rf_raddr2`, one cycle after the request |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Write address |
| rf_wdata | output | 32 | Write data |

## Verification
The hardest situation to bring about is a read landing on the same edge as the previous element's write to that register. In that case the register file returns the stale value and only the bypass can supply the correct one. The stimulus forces this in two ways. One case uses a destination range that starts one register above the first source range, which builds a running prefix chain. The other uses a scalar destination that is also a scalar source, so every element accumulates into the same register. A third case wraps the destination through register 0 and back into the source range, so the dropped write and the bypass are exercised together.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int XLEN_D  = 32;
  localparam int AW_D    = 5;
  localparam int MAXVL_D = 16;
  localparam int NOPND   = 3;
  // operand slot positions inside the packed operand buses
  localparam int SLOT_DST  = 0;
  localparam int SLOT_SRC1 = 1;
  localparam int SLOT_SRC2 = 2;
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl #(
  parameter  int MAXVL = vseq_pkg::MAXVL_D,
  localparam int VLW   = $clog2(MAXVL + 1),
  localparam int IW    = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vlen,
  output logic           accept,
  output logic           issue,
  output logic [IW-1:0]  idx,
  output logic           wr_stage,
  output logic           busy,
  output logic           done
);
  logic           run_q, wv_q, wlast_q, zdone_q;
  logic [IW-1:0]  idx_q, last_q;
  logic [VLW-1:0] n_eff;

  assign n_eff  = (vlen > VLW'(MAXVL)) ? VLW'(MAXVL) : vlen;
  assign busy   = run_q | wv_q;
  assign accept = start & ~busy & ~zdone_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      zdone_q <= 1'b0;
      wv_q    <= 1'b0;
      wlast_q <= 1'b0;
    end else begin
      zdone_q <= 1'b0;
      if (accept) begin
        if (n_eff == '0) begin
          zdone_q <= 1'b1;
        end else begin
          run_q  <= 1'b1;
          idx_q  <= '0;
          last_q <= IW'(n_eff - VLW'(1));
        end
      end else if (run_q) begin
        idx_q <= idx_q + IW'(1);
        if (idx_q == last_q) run_q <= 1'b0;
      end
      wv_q    <= run_q;
      wlast_q <= run_q && (idx_q == last_q);
    end
  end

  assign issue    = run_q;
  assign idx      = idx_q;
  assign wr_stage = wv_q;
  assign done     = (wv_q & wlast_q) | zdone_q;

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/vseq_offsets.sv
module vseq_offsets #(
  parameter int AW   = vseq_pkg::AW_D,
  parameter int NOPS = vseq_pkg::NOPND
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    issue,
  input  logic [NOPS-1:0][AW-1:0] base_in,
  input  logic [NOPS-1:0]         vec_in,
  output logic [NOPS-1:0][AW-1:0] addr
);
  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic [AW-1:0] base_q, off_q;
    logic          vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        off_q  <= '0;
        vec_q  <= 1'b0;
      end else if (accept) begin
        base_q <= base_in[g];
        vec_q  <= vec_in[g];
        off_q  <= '0;
      end else if (issue && vec_q) begin
        off_q <= off_q + AW'(1);
      end
    end

    // wraps modulo 2^AW
    assign addr[g] = base_q + off_q;

    p_scalar_reuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && $past(issue) && !vec_q) |-> $stable(addr[g]));
  end
endmodule

// File: rtl/vseq_alu.sv
module vseq_alu #(
  parameter int XLEN = vseq_pkg::XLEN_D,
  parameter int AW   = vseq_pkg::AW_D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [AW-1:0]   raddr1,
  input  logic [AW-1:0]   raddr2,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [XLEN-1:0] rdata1,
  input  logic [XLEN-1:0] rdata2,
  output logic [XLEN-1:0] sum
);
  // A read issued on the same edge as a write returns the old value;
  // capture the value being written so the next element sees it.
  logic            byp1_q, byp2_q;
  logic [XLEN-1:0] bd1_q, bd2_q;
  logic [XLEN-1:0] op1, op2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp1_q <= 1'b0;
      byp2_q <= 1'b0;
      bd1_q  <= '0;
      bd2_q  <= '0;
    end else begin
      byp1_q <= issue && wr_en && (wr_addr == raddr1);
      byp2_q <= issue && wr_en && (wr_addr == raddr2);
      bd1_q  <= wr_data;
      bd2_q  <= wr_data;
    end
  end

  assign op1 = byp1_q ? bd1_q : rdata1;
  assign op2 = byp2_q ? bd2_q : rdata2;
  assign sum = op1 + op2;
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter  int XLEN  = vseq_pkg::XLEN_D,
  parameter  int AW    = vseq_pkg::AW_D,
  parameter  int MAXVL = vseq_pkg::MAXVL_D,
  localparam int VLW   = $clog2(MAXVL + 1),
  localparam int IW    = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vlen,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic [AW-1:0]    rd_base,
  input  logic             rd_vec,
  input  logic [AW-1:0]    rs1_base,
  input  logic             rs1_vec,
  input  logic [AW-1:0]    rs2_base,
  input  logic             rs2_vec,
  output logic             busy,
  output logic             done,
  output logic             rf_re,
  output logic [AW-1:0]    rf_raddr1,
  output logic [AW-1:0]    rf_raddr2,
  input  logic [XLEN-1:0]  rf_rdata1,
  input  logic [XLEN-1:0]  rf_rdata2,
  output logic             rf_we,
  output logic [AW-1:0]    rf_waddr,
  output logic [XLEN-1:0]  rf_wdata
);
  import vseq_pkg::*;

  logic                     accept, issue, wr_stage;
  logic [IW-1:0]            idx;
  logic [NOPND-1:0][AW-1:0] base_bus, addr_bus;
  logic [NOPND-1:0]         vec_bus;
  logic [MAXVL-1:0]         mask_q;
  logic [AW-1:0]            wa_q;
  logic                     wp_q;
  logic [XLEN-1:0]          sum;

  vseq_ctrl #(.MAXVL(MAXVL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
    .accept(accept), .issue(issue), .idx(idx), .wr_stage(wr_stage),
    .busy(busy), .done(done)
  );

  always_comb begin
    base_bus[SLOT_DST]  = rd_base;
    base_bus[SLOT_SRC1] = rs1_base;
    base_bus[SLOT_SRC2] = rs2_base;
    vec_bus[SLOT_DST]   = rd_vec;
    vec_bus[SLOT_SRC1]  = rs1_vec;
    vec_bus[SLOT_SRC2]  = rs2_vec;
  end

  vseq_offsets #(.AW(AW), .NOPS(NOPND)) u_offs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .issue(issue),
    .base_in(base_bus), .vec_in(vec_bus), .addr(addr_bus)
  );

  // write stage: destination and predicate follow the read by one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      wa_q   <= '0;
      wp_q   <= 1'b0;
    end else begin
      if (accept) mask_q <= pred_mask;
      if (issue) begin
        wa_q <= addr_bus[SLOT_DST];
        wp_q <= mask_q[idx];
      end
    end
  end

  assign rf_re     = issue;
  assign rf_raddr1 = addr_bus[SLOT_SRC1];
  assign rf_raddr2 = addr_bus[SLOT_SRC2];
  assign rf_we     = wr_stage & wp_q & (wa_q != '0);
  assign rf_waddr  = wa_q;
  assign rf_wdata  = sum;

  vseq_alu #(.XLEN(XLEN), .AW(AW)) u_alu (
    .clk(clk), .rst_n(rst_n), .issue(issue),
    .raddr1(rf_raddr1), .raddr2(rf_raddr2),
    .wr_en(rf_we), .wr_addr(rf_waddr), .wr_data(rf_wdata),
    .rdata1(rf_rdata1), .rdata2(rf_rdata2), .sum(sum)
  );

  p_we_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);

  p_no_zero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != '0));

  p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(rf_re));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rf_re && !rf_we));
endmodule

// File: tb/sim_vec_elem_seq.sv
module sim_vec_elem_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  vlen = '0;
  logic [15:0] pred_mask = '0;
  logic [4:0]  rd_base = '0, rs1_base = '0, rs2_base = '0;
  logic        rd_vec = 1'b0, rs1_vec = 1'b0, rs2_vec = 1'b0;
  logic        busy, done, rf_re, rf_we;
  logic [4:0]  rf_raddr1, rf_raddr2, rf_waddr;
  logic [31:0] rf_rdata1, rf_rdata2, rf_wdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_elem_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .pred_mask(pred_mask),
    .rd_base(rd_base), .rd_vec(rd_vec), .rs1_base(rs1_base), .rs1_vec(rs1_vec),
    .rs2_base(rs2_base), .rs2_vec(rs2_vec), .busy(busy), .done(done),
    .rf_re(rf_re), .rf_raddr1(rf_raddr1), .rf_raddr2(rf_raddr2),
    .rf_rdata1(rf_rdata1), .rf_rdata2(rf_rdata2),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  // register-file model: synchronous read, write at the edge
  logic [31:0] mem [32];
  logic [31:0] refm [32];
  logic        load = 1'b0;
  logic [31:0] seed = '0;
  int wr_cnt = 0;
  int rd_cnt = 0;

  always @(posedge clk) begin
    if (load) begin
      for (int k = 0; k < 32; k++)
        mem[k] <= (k == 0) ? 32'd0 : (32'(k) * 32'h0100_0193 + seed);
    end else begin
      if (rf_re) begin
        rf_rdata1 <= mem[rf_raddr1];
        rf_rdata2 <= mem[rf_raddr2];
        rd_cnt <= rd_cnt + 1;
      end
      if (rf_we) begin
        mem[rf_waddr] <= rf_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_rf(input logic [31:0] s);
    @(negedge clk);
    seed = s;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // sequential reference of the element loop; returns expected write count
  task automatic model(input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2,
                       input bit vd, input bit v1, input bit v2, input logic [4:0] vl,
                       input logic [15:0] mk, output int n, output int exp_w);
    logic [4:0] od, o1, o2, d;
    for (int k = 0; k < 32; k++) refm[k] = mem[k];
    n = (vl > 5'd16) ? 16 : int'(vl);
    exp_w = 0;
    od = '0; o1 = '0; o2 = '0;
    for (int i = 0; i < n; i++) begin
      d = rd + od;
      if (mk[i] && d != 5'd0) begin
        refm[d] = refm[5'(r1 + o1)] + refm[5'(r2 + o2)];
        exp_w++;
      end
      if (vd) od = od + 5'd1;
      if (v1) o1 = o1 + 5'd1;
      if (v2) o2 = o2 + 5'd1;
    end
  endtask

  task automatic cmp_rf(input string req);
    int bad = -1;
    for (int k = 0; k < 32; k++)
      if (bad < 0 && mem[k] !== refm[k]) bad = k;
    if (bad < 0) chk(1'b1, req, "register file", 0, 0);
    else chk(1'b0, req, $sformatf("register x%0d", bad), longint'(mem[bad]), longint'(refm[bad]));
  endtask

  task automatic drive(input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2,
                       input bit vd, input bit v1, input bit v2, input logic [4:0] vl,
                       input logic [15:0] mk);
    rd_base = rd; rs1_base = r1; rs2_base = r2;
    rd_vec = vd; rs1_vec = v1; rs2_vec = v2;
    vlen = vl; pred_mask = mk;
  endtask

  task automatic run_op(input string req, input logic [4:0] rd, input logic [4:0] r1,
                        input logic [4:0] r2, input bit vd, input bit v1, input bit v2,
                        input logic [4:0] vl, input logic [15:0] mk);
    int n, exp_w, cnt, w0, r0;
    model(rd, r1, r2, vd, v1, v2, vl, mk, n, exp_w);
    @(negedge clk);
    drive(rd, r1, r2, vd, v1, v2, vl, mk);
    w0 = wr_cnt; r0 = rd_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == (n != 0), (n != 0) ? "R1" : "R9", {req, " busy after start"}, busy, n != 0);
    cnt = 0;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == n, "R1", {req, " done latency"}, cnt, n);
    @(negedge clk);
    cmp_rf(req);
    chk(wr_cnt - w0 == exp_w, "R5", {req, " write count"}, wr_cnt - w0, exp_w);
    chk(rd_cnt - r0 == n, "R2", {req, " read count"}, rd_cnt - r0, n);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !rf_re && !rf_we, "R11", "reset outputs",
        {busy, done, rf_re, rf_we}, 0);
  endtask

  task automatic t_vec_vec();
    load_rf(32'h1111_0000);
    run_op("R6 vector+vector", 5'd10, 5'd1, 5'd17, 1, 1, 1, 5'd4, 16'hFFFF);
  endtask

  task automatic t_scalar_src();
    load_rf(32'h2222_0000);
    run_op("R4 scalar src2", 5'd12, 5'd2, 5'd20, 1, 1, 0, 5'd5, 16'hFFFF);
  endtask

  task automatic t_pred();
    load_rf(32'h3333_0000);
    run_op("R5 predicated", 5'd3, 5'd15, 5'd22, 1, 1, 1, 5'd8, 16'h00A5);
  endtask

  task automatic t_scalar_dst();
    load_rf(32'h4444_0000);
    run_op("R4 scalar dest", 5'd9, 5'd18, 5'd24, 0, 1, 1, 5'd3, 16'h0005);
  endtask

  task automatic t_chain();
    load_rf(32'h5555_0000);
    run_op("R7 prefix chain", 5'd8, 5'd7, 5'd1, 1, 1, 0, 5'd6, 16'hFFFF);
  endtask

  task automatic t_accum();
    load_rf(32'h6666_0000);
    run_op("R7 scalar accumulate", 5'd5, 5'd5, 5'd20, 0, 0, 1, 5'd7, 16'hFFFF);
  endtask

  task automatic t_wrap_zero();
    load_rf(32'h7777_0000);
    run_op("R3 R8 wrap through x0", 5'd30, 5'd29, 5'd5, 1, 1, 0, 5'd4, 16'hFFFF);
    chk(mem[0] == 32'd0, "R8", "x0 stays zero", longint'(mem[0]), 0);
  endtask

  task automatic t_len0();
    load_rf(32'h8888_0000);
    run_op("R9 zero length", 5'd4, 5'd6, 5'd7, 1, 1, 1, 5'd0, 16'hFFFF);
  endtask

  task automatic t_clamp();
    load_rf(32'h9999_0000);
    run_op("R2 length clamp", 5'd16, 5'd0, 5'd3, 1, 1, 0, 5'd25, 16'hFFFF);
  endtask

  task automatic t_busy_start();
    int n, exp_w, cnt, w0;
    load_rf(32'hAAAA_0000);
    model(5'd20, 5'd1, 5'd2, 1, 1, 0, 5'd6, 16'h002F, n, exp_w);
    @(negedge clk);
    drive(5'd20, 5'd1, 5'd2, 1, 1, 0, 5'd6, 16'h002F);
    w0 = wr_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    drive(5'd3, 5'd4, 5'd5, 1, 1, 1, 5'd9, 16'hFFFF);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 3;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == n, "R10", "done latency with ignored start", cnt, n);
    @(negedge clk);
    cmp_rf("R10");
    chk(wr_cnt - w0 == exp_w, "R10", "write count with ignored start", wr_cnt - w0, exp_w);
    repeat (4) @(negedge clk);
    chk(!busy && (wr_cnt - w0 == exp_w), "R10", "no second operation", wr_cnt - w0, exp_w);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vec_vec();
    t_scalar_src();
    t_pred();
    t_scalar_dst();
    t_chain();
    t_accum();
    t_wrap_zero();
    t_len0();
    t_clamp();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule